// File: doc/BRIEF.md
# Sequential Unsigned 16-by-8 Divider

This block divides a 16-bit unsigned dividend by an 8-bit unsigned divisor over several clock cycles. It returns one 16-bit word, with the quotient in the low byte and the remainder in the high byte. It also returns four status flags: carry, zero, sign and overflow. The surrounding execution unit pulses `start` with both operands and sees `busy` while the operation runs. A one-cycle `done` pulse then marks the moment the result word and the flags are updated.

The cycle count depends only on the divisor. A divide by zero always takes the short latency and every other divide takes the long one, so the pipeline that issues the operation can plan around a fixed count.

Internally, a restoring shift-subtract loop develops nine quotient bits. Quotients from 256 to 511 are therefore known exactly and reported through the carry flag. A separate comparison at start-up detects quotients of 512 or more.

Top module: `div16x8_seq`

## Requirements
- R1: For a non-zero divisor and a true quotient below 256, `result[7:0]` is the quotient and `result[15:8]` is the remainder. For example, 1003h / 40h gives 0340h, 1003h / 80h gives 0320h and 1003h / 20h gives 0380h.
- R2: `flag_v` is 1 when the divisor is zero or the true quotient is 256 or more, and 0 otherwise.
- R3: `flag_c` is 1 only when the true quotient lies in the range 256 to 511 inclusive, and 0 otherwise. This includes a zero divisor and quotients of 512 or more.
- R4: `flag_z` is 1 when the divisor is zero or when the stored 8-bit quotient `result[7:0]` is zero, and 0 otherwise.
- R5: `flag_s` equals `result[7]` after any divide with a non-zero divisor, and it is 0 after a divide by zero.
- R6: `done` is a one-cycle pulse that rises exactly LAT_RUN (default 26) clock edges after the edge that accepts `start`. For a zero divisor it rises after LAT_ZERO (default 10) edges instead. `busy` is 1 from the accepting edge until `done` rises, and the outputs change only when `done` rises.
- R7: A divide by zero leaves `result` unchanged.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. It changes neither the latency nor the result of the divide already running.
- R9: When the true quotient is between 256 and 511, `result[7:0]` holds the low 8 bits of the quotient and `result[15:8]` holds the exact remainder.
- R10: A synchronous active-high `rst` clears `busy`, `done`, `result` and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide with the presented operands |
| dividend | input | 16 | Unsigned dividend |
| divisor | input | 8 | Unsigned divisor |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle pulse: result and flags just updated |
| result | output | 16 | {remainder, quotient} |
| flag_c | output | 1 | Quotient lies in 256..511 |
| flag_z | output | 1 | Divisor zero or stored quotient zero |
| flag_s | output | 1 | Bit 7 of the stored quotient |
| flag_v | output | 1 | Quotient overflow or divisor zero |

## Verification
Suppose the cycle counter is wrong or gets reloaded. Then `busy` and `done` disagree with the reference model on the first cycle the bad count reaches its end, and that cycle is always within one operation's latency.

Suppose instead a shift-subtract step or the remainder register is corrupted. Then the fault is hidden until the `done` edge, where the whole result word and the flags derived from it are compared.

A wrong captured overflow or zero-divisor state shows up as a flag mismatch on that same edge. For a zero divisor it can also show up as an early or late `done`.

// File: rtl/div16x8_seq.sv
module div16x8_seq #(
  parameter int unsigned LAT_RUN  = 26,
  parameter int unsigned LAT_ZERO = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] dividend,
  input  logic [7:0]  divisor,
  output logic        busy,
  output logic        done,
  output logic [15:0] result,
  output logic        flag_c,
  output logic        flag_z,
  output logic        flag_s,
  output logic        flag_v
);
  localparam int unsigned CW = $clog2(LAT_RUN + 1);

  logic [CW-1:0] cnt;
  logic [3:0]    steps;
  logic [7:0]    dvs, rem;
  logic [8:0]    sh;
  logic          by_zero, too_big;

  logic [8:0] trial;
  logic       fits;
  logic [7:0] diff;
  logic       big_in;

  assign trial  = {rem, sh[8]};
  assign fits   = trial >= {1'b0, dvs};
  assign diff   = trial[7:0] - dvs;
  assign big_in = {1'b0, dividend} >= {divisor, 9'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
      flag_s  <= 1'b0;
      flag_v  <= 1'b0;
      cnt     <= '0;
      steps   <= '0;
      dvs     <= '0;
      rem     <= '0;
      sh      <= '0;
      by_zero <= 1'b0;
      too_big <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          dvs     <= divisor;
          rem     <= {1'b0, dividend[15:9]};
          sh      <= dividend[8:0];
          by_zero <= (divisor == 8'd0);
          too_big <= big_in;
          steps   <= 4'd9;
          cnt     <= (divisor == 8'd0) ? CW'(LAT_ZERO - 1) : CW'(LAT_RUN - 1);
        end
      end else begin
        if (steps != 4'd0) begin
          steps <= steps - 4'd1;
          rem   <= fits ? diff : trial[7:0];
          sh    <= {sh[7:0], fits};
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (by_zero) begin
            flag_v <= 1'b1;
            flag_z <= 1'b1;
            flag_c <= 1'b0;
            flag_s <= 1'b0;
          end else begin
            result <= {rem, sh[7:0]};
            flag_v <= too_big | sh[8];
            flag_c <= ~too_big & sh[8];
            flag_z <= (sh[7:0] == 8'd0);
            flag_s <= sh[7];
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/div16x8_seq_chk.sv
module div16x8_seq_chk #(
  parameter int unsigned LAT_RUN  = 26,
  parameter int unsigned LAT_ZERO = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  divisor,
  input logic        busy,
  input logic        done,
  input logic [15:0] result,
  input logic        flag_c,
  input logic        flag_z,
  input logic        flag_s,
  input logic        flag_v
);
  logic        zcap;
  logic [15:0] rcap;
  int unsigned el;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcap <= 1'b0;
      rcap <= '0;
      el   <= 0;
    end else if (!busy && start) begin
      zcap <= (divisor == 8'd0);
      rcap <= result;
      el   <= 0;
    end else if (busy) begin
      el <= el + 1;
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> el == (zcap ? LAT_ZERO : LAT_RUN));
  p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
  p_c_within_v_r3: assert property (@(posedge clk) disable iff (rst)
    flag_c |-> flag_v);
  p_zero_flags_r2: assert property (@(posedge clk) disable iff (rst)
    done && zcap |-> flag_v && flag_z && !flag_c && !flag_s);
  p_zero_keeps_result_r7: assert property (@(posedge clk) disable iff (rst)
    done && zcap |-> result == rcap);
  p_sign_r5: assert property (@(posedge clk) disable iff (rst)
    done && !zcap |-> flag_s == result[7]);
  p_zero_quot_r4: assert property (@(posedge clk) disable iff (rst)
    done && !zcap |-> flag_z == (result[7:0] == 8'd0));
endmodule

bind div16x8_seq div16x8_seq_chk #(.LAT_RUN(LAT_RUN), .LAT_ZERO(LAT_ZERO)) u_chk (
  .clk(clk), .rst(rst), .start(start), .divisor(divisor), .busy(busy), .done(done),
  .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
);

// File: tb/tb_div16x8_seq.sv
module tb_div16x8_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [7:0]  divisor = '0;
  logic        busy, done, flag_c, flag_z, flag_s, flag_v;
  logic [15:0] result;

  div16x8_seq dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // reference model state
  logic        m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [15:0] m_res = 0;
  logic        m_res_known = 1;
  logic        m_c = 0, m_z = 0, m_s = 0, m_v = 0, m_zs_known = 1;
  logic [15:0] p_res;
  logic        p_known, p_c, p_z, p_s, p_v, p_zs_known;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      m_res = 0; m_res_known = 1;
      m_c = 0; m_z = 0; m_s = 0; m_v = 0; m_zs_known = 1;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_res = p_res; m_res_known = p_known;
          m_c = p_c; m_z = p_z; m_s = p_s; m_v = p_v; m_zs_known = p_zs_known;
        end
      end else if (start) begin
        m_busy = 1;
        if (divisor == 0) begin
          m_cnt = 10;
          p_res = m_res; p_known = m_res_known;
          p_v = 1; p_z = 1; p_c = 0; p_s = 0; p_zs_known = 1;
        end else begin
          int q, r;
          m_cnt = 26;
          q = int'(dividend) / int'(divisor);
          r = int'(dividend) % int'(divisor);
          p_v = (q >= 256);
          p_c = (q >= 256) && (q < 512);
          if (q < 512) begin
            p_res = {r[7:0], q[7:0]}; p_known = 1;
            p_z = (q[7:0] == 0); p_s = q[7]; p_zs_known = 1;
          end else begin
            p_res = 0; p_known = 0; p_z = 0; p_s = 0; p_zs_known = 0;
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk(busy === m_busy, "R6 R8 R10 busy", 16'(busy), 16'(m_busy));
    chk(done === m_done, "R6 R8 R10 done", 16'(done), 16'(m_done));
    if (m_res_known)
      chk(result === m_res, "R1 R7 R9 R10 result", result, m_res);
    chk(flag_v === m_v, "R2 flag_v", 16'(flag_v), 16'(m_v));
    chk(flag_c === m_c, "R3 flag_c", 16'(flag_c), 16'(m_c));
    if (m_zs_known) begin
      chk(flag_z === m_z, "R4 flag_z", 16'(flag_z), 16'(m_z));
      chk(flag_s === m_s, "R5 flag_s", 16'(flag_s), 16'(m_s));
    end else begin
      chk(flag_z === (result[7:0] == 8'd0), "R4 flag_z on stored quotient", 16'(flag_z), 16'(result[7:0] == 8'd0));
      chk(flag_s === result[7], "R5 flag_s on stored quotient", 16'(flag_s), 16'(result[7]));
    end
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic do_div(input logic [15:0] dvd, input logic [7:0] dvs, input int gap);
    @(negedge clk);
    start = 1; dividend = dvd; divisor = dvs;
    @(negedge clk);
    start = 0; dividend = $urandom; divisor = $urandom;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 worked examples
    do_div(16'h1003, 8'h40, 27);
    do_div(16'h1003, 8'h80, 27);
    do_div(16'h1003, 8'h20, 27);
    // R4 zero quotient
    do_div(16'h0005, 8'h07, 27);
    // R3 R9 quotient 257, exactly 256, and 511 with remainder 99
    do_div(16'hFFFF, 8'hFF, 27);
    do_div(16'h0300, 8'h03, 27);
    do_div(16'hC7FF, 8'd100, 27);
    // R2 large overflow
    do_div(16'hFFFF, 8'h01, 27);
    // R7 zero divisor after a known result
    do_div(16'h1003, 8'h40, 27);
    do_div(16'h1234, 8'h00, 12);
    // R8 start while busy is ignored
    do_div(16'h1234, 8'h56, 5);
    do_div(16'hFFFF, 8'h00, 25);
    do_div(16'h0000, 8'h00, 3);
    do_div(16'h00FF, 8'h01, 12);
    // back-to-back start on the done cycle
    do_div(16'h8000, 8'h09, 25);
    do_div(16'h7777, 8'h88, 27);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d;
      logic [15:0] n;
      d = (($urandom % 8) == 0) ? 8'd0 : 8'($urandom);
      if (($urandom % 3) == 0 && d != 0)
        n = 16'((256 + ($urandom % 256)) * int'(d) + ($urandom % int'(d)));
      else
        n = 16'($urandom);
      do_div(n, d, $urandom % 32);
    end
    repeat (30) @(negedge clk);
    // R10 reset in the middle of a divide
    do_div(16'hABCD, 8'h12, 4);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule